// File: doc/BRIEF.md
# Seconds-Counting Real-Time Clock with Compare Alarm

This block is a memory-mapped real-time clock for a system-on-chip. A 32-bit seconds count advances once per second. The one-second tick comes from a prescaler that divides the system clock by a parameter. Each tick sets a once-per-second event flag. A compare register sets an alarm event flag when the count reaches the stored value. Each flag has its own interrupt enable, and the two enabled flags are combined into one interrupt line. The block also holds a hibernate request bit, which drives a power-off request output. A scratchpad word survives a soft reset, so firmware can tell a warm restart from a cold start by leaving a marker value there.

Software reaches the block over a plain synchronous register bus with an address, a write strobe, write data and combinational read data. Every write is gated by a write-ready status bit in the control register. After a write is accepted, that bit stays low for a fixed number of cycles, which stands in for a slow clock domain. Software must poll the bit before each write. Writes made while it is low are dropped.

The two event flags in the control register are cleared by writing 0 to them and kept by writing 1. Software can therefore rewrite the enable bits without losing a pending event.

Top module: `rtc_secs_alarm`

## Requirements
- R1: After power-on reset every register reads 0 except write-ready (control bit 7), which reads 1. The interrupt and power-off request outputs are 0.
- R2: A write is taken only while write-ready is 1. After an accepted write, write-ready reads 0 for exactly WR_HOLD cycles, and writes presented on those edges are dropped.
- R3: While counter enable (control bit 0) is 1, the seconds register (offset 0x04) increments once every TICK_DIV cycles. The first increment comes TICK_DIV cycles after the enabling write. While counter enable is 0, the register holds its value.
- R4: Each tick sets the one-second flag (control bit 6).
- R5: The alarm flag (control bit 4) is set on the tick that makes the seconds count equal to the alarm register (offset 0x08), but only while alarm enable (control bit 2) is 1. With alarm enable 0, no alarm flag is set.
- R6: Writing 0 to a flag bit in the control register clears that flag, and writing 1 keeps it. If an event arrives in the same cycle as a clearing write, the flag ends up set.
- R7: The interrupt output is (bit6 AND bit5) OR (bit4 AND bit3) of the control register.
- R8: Bit 0 of the hibernate register (offset 0x20) reads back as written and drives the power-off request output.
- R9: The scratchpad (offset 0x34) is a full 32-bit read/write word. It keeps its value through a soft reset and is cleared by power-on reset.
- R10: A one-cycle soft reset clears the control, alarm, regulator and hibernate registers and ends any write-ready hold. It leaves the seconds count and the scratchpad unchanged, and drops a write presented in the same cycle.
- R11: When a write to the seconds register lands on a tick, the written value is stored and the increment is lost.
- R12: The regulator word (offset 0x0C) is a 32-bit read/write register. Any unmapped offset reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| soft_rst | input | 1 | Synchronous soft reset, active high |
| bus_addr | input | 6 | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Combined interrupt request |
| pwr_off_req | output | 1 | Power-off request from the hibernate register |

## Verification
Two pairs of operations can land on the same clock edge. A control write that clears the one-second flag can coincide with a prescaler tick. A write to the seconds register can also coincide with a tick. The bench uses a small prescaler ratio and counts cycles from the enabling write, so it can place each write exactly on a tick edge. It then expects the flag to stay set, and the seconds register to hold the written value rather than that value plus one. The write-ready window is swept by issuing a second write at every offset from one to WR_HOLD+1 edges after an accepted write. Only the last of these writes may reach the scratchpad.

// File: rtl/rtc_sa_pkg.sv
package rtc_sa_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 32;

  // register byte offsets
  localparam logic [ADDR_W-1:0] OFS_CTRL = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_SECS = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_ALRM = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_TRIM = 6'h0C;
  localparam logic [ADDR_W-1:0] OFS_HIB  = 6'h20;
  localparam logic [ADDR_W-1:0] OFS_SCR  = 6'h34;

  // control bit positions
  localparam int CB_RDY  = 7;
  localparam int CB_HZF  = 6;
  localparam int CB_HZIE = 5;
  localparam int CB_ALF  = 4;
  localparam int CB_ALIE = 3;
  localparam int CB_ALEN = 2;
  localparam int CB_RUN  = 0;

  // sticky event flag: a written 0 clears it, a written 1 keeps it, an event sets it
  function automatic logic flag_upd(logic cur, logic wr, logic wbit, logic evt);
    return evt | (cur & ~(wr & ~wbit));
  endfunction

  function automatic logic [DATA_W-1:0] sec_next(logic [DATA_W-1:0] s);
    return s + 1'b1;
  endfunction

  function automatic logic alarm_hit(logic en, logic [DATA_W-1:0] nxt, logic [DATA_W-1:0] cmp);
    return en && (nxt == cmp);
  endfunction
endpackage

// File: rtl/rtc_sa_presc.sv
module rtc_sa_presc #(
  parameter int DIV = 32768
) (
  input  logic clk,
  input  logic por_n,
  input  logic clr,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick = !clr && (cnt_q == LAST);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)      cnt_q <= '0;
    else if (clr)    cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  generate
    if (DIV > 1) begin : g_gap
      p_tick_gap_r3: assert property (@(posedge clk) disable iff (!por_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/rtc_sa_wgate.sv
module rtc_sa_wgate #(
  parameter int HOLD = 4
) (
  input  logic clk,
  input  logic por_n,
  input  logic soft_rst,
  input  logic we,
  output logic ready,
  output logic acc
);
  localparam int CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] HOLD_V = CW'(HOLD);

  logic [CW-1:0] busy_q;

  assign ready = (busy_q == '0);
  assign acc   = we && ready && !soft_rst;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)              busy_q <= '0;
    else if (soft_rst)       busy_q <= '0;
    else if (acc)            busy_q <= HOLD_V;
    else if (busy_q != '0)   busy_q <= busy_q - 1'b1;
  end

  // write-ready only drops because a write was presented
  p_ready_fall_r2: assert property (@(posedge clk) disable iff (!por_n)
    $fell(ready) |-> $past(we));
endmodule

// File: rtl/rtc_secs_alarm.sv
module rtc_secs_alarm
  import rtc_sa_pkg::*;
#(
  parameter int TICK_DIV = 32768,
  parameter int WR_HOLD  = 4
) (
  input  logic        clk,
  input  logic        por_n,
  input  logic        soft_rst,
  input  logic [5:0]  bus_addr,
  input  logic        bus_we,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  output logic        pwr_off_req
);
  logic wready, w_acc, tick;
  logic wr_ctrl, wr_secs, wr_alrm, wr_trim, wr_hib, wr_scr;
  logic hz_evt, al_evt;
  logic hz_f, hz_ie, al_f, al_ie, al_en, cnt_en;
  logic [DATA_W-1:0] secs_q, alrm_q, trim_q, scr_q;
  logic hib_q;

  rtc_sa_wgate #(.HOLD(WR_HOLD)) u_wgate (
    .clk(clk), .por_n(por_n), .soft_rst(soft_rst), .we(bus_we),
    .ready(wready), .acc(w_acc)
  );

  rtc_sa_presc #(.DIV(TICK_DIV)) u_presc (
    .clk(clk), .por_n(por_n), .clr(soft_rst || !cnt_en), .tick(tick)
  );

  assign wr_ctrl = w_acc && (bus_addr == OFS_CTRL);
  assign wr_secs = w_acc && (bus_addr == OFS_SECS);
  assign wr_alrm = w_acc && (bus_addr == OFS_ALRM);
  assign wr_trim = w_acc && (bus_addr == OFS_TRIM);
  assign wr_hib  = w_acc && (bus_addr == OFS_HIB);
  assign wr_scr  = w_acc && (bus_addr == OFS_SCR);

  assign hz_evt = tick;
  assign al_evt = tick && !wr_secs && alarm_hit(al_en, sec_next(secs_q), alrm_q);

  // seconds count: kept through soft reset, a write beats a tick
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)       secs_q <= '0;
    else if (wr_secs) secs_q <= bus_wdata;
    else if (tick)    secs_q <= sec_next(secs_q);
  end

  // scratchpad: only power-on reset clears it
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)      scr_q <= '0;
    else if (wr_scr) scr_q <= bus_wdata;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      {hz_f, hz_ie, al_f, al_ie, al_en, cnt_en} <= '0;
      alrm_q <= '0;
      trim_q <= '0;
      hib_q  <= 1'b0;
    end else if (soft_rst) begin
      {hz_f, hz_ie, al_f, al_ie, al_en, cnt_en} <= '0;
      alrm_q <= '0;
      trim_q <= '0;
      hib_q  <= 1'b0;
    end else begin
      hz_f <= flag_upd(hz_f, wr_ctrl, bus_wdata[CB_HZF], hz_evt);
      al_f <= flag_upd(al_f, wr_ctrl, bus_wdata[CB_ALF], al_evt);
      if (wr_ctrl) begin
        hz_ie  <= bus_wdata[CB_HZIE];
        al_ie  <= bus_wdata[CB_ALIE];
        al_en  <= bus_wdata[CB_ALEN];
        cnt_en <= bus_wdata[CB_RUN];
      end
      if (wr_alrm) alrm_q <= bus_wdata;
      if (wr_trim) trim_q <= bus_wdata;
      if (wr_hib)  hib_q  <= bus_wdata[0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_CTRL: begin
        bus_rdata[CB_RDY]  = wready;
        bus_rdata[CB_HZF]  = hz_f;
        bus_rdata[CB_HZIE] = hz_ie;
        bus_rdata[CB_ALF]  = al_f;
        bus_rdata[CB_ALIE] = al_ie;
        bus_rdata[CB_ALEN] = al_en;
        bus_rdata[CB_RUN]  = cnt_en;
      end
      OFS_SECS: bus_rdata = secs_q;
      OFS_ALRM: bus_rdata = alrm_q;
      OFS_TRIM: bus_rdata = trim_q;
      OFS_HIB:  bus_rdata[0] = hib_q;
      OFS_SCR:  bus_rdata = scr_q;
      default:  bus_rdata = '0;
    endcase
  end

  assign irq         = (hz_f && hz_ie) || (al_f && al_ie);
  assign pwr_off_req = hib_q;

  p_busy_drop_r2: assert property (@(posedge clk) disable iff (!por_n)
    (bus_we && !wready && bus_addr == OFS_SCR) |=> $stable(scr_q));
  p_secs_hold_r3: assert property (@(posedge clk) disable iff (!por_n)
    (!cnt_en && !bus_we) |=> $stable(secs_q));
  p_hz_set_r4: assert property (@(posedge clk) disable iff (!por_n)
    tick |=> hz_f);
  p_alarm_gated_r5: assert property (@(posedge clk) disable iff (!por_n)
    $rose(al_f) |-> $past(al_en));
  p_event_wins_r6: assert property (@(posedge clk) disable iff (!por_n)
    al_evt |=> al_f);
  p_irq_source_r7: assert property (@(posedge clk) disable iff (!por_n)
    irq |-> (hz_f || al_f));
  p_hib_cause_r8: assert property (@(posedge clk) disable iff (!por_n)
    $rose(pwr_off_req) |-> $past(bus_we && bus_addr == OFS_HIB));
  p_scr_keep_r9: assert property (@(posedge clk) disable iff (!por_n)
    soft_rst |=> $stable(scr_q));
  p_soft_clear_r10: assert property (@(posedge clk) disable iff (!por_n)
    soft_rst |=> (!cnt_en && !pwr_off_req && alrm_q == '0 && wready));
  p_write_wins_r11: assert property (@(posedge clk) disable iff (!por_n)
    (tick && wr_secs) |=> (secs_q == $past(bus_wdata)));
endmodule

// File: tb/sim_rtc_secs_alarm.sv
module sim_rtc_secs_alarm;
  localparam int DIV  = 8;
  localparam int HOLD = 4;
  localparam logic [5:0] A_CTRL = 6'h00, A_SECS = 6'h04, A_ALRM = 6'h08;
  localparam logic [5:0] A_TRIM = 6'h0C, A_HIB = 6'h20, A_SCR = 6'h34, A_NONE = 6'h10;

  logic clk = 1'b0, por_n = 1'b0, soft_rst = 1'b0, we = 1'b0;
  logic [5:0] addr = '0;
  logic [31:0] wd = '0;
  logic [31:0] rdata;
  logic irq, poff;
  int checks = 0, errors = 0;
  logic [31:0] v, s_keep;

  always #10 clk = ~clk;

  rtc_secs_alarm #(.TICK_DIV(DIV), .WR_HOLD(HOLD)) u0 (
    .clk(clk), .por_n(por_n), .soft_rst(soft_rst), .bus_addr(addr),
    .bus_we(we), .bus_wdata(wd), .bus_rdata(rdata), .irq(irq), .pwr_off_req(poff)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic raw_wr(input logic [5:0] a, input logic [31:0] d);
    addr = a; wd = d; we = 1'b1;
    @(posedge clk); @(negedge clk);
    we = 1'b0;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    logic [31:0] c;
    forever begin
      rd(A_CTRL, c);
      if (c[7]) break;
      @(negedge clk);
    end
    raw_wr(a, d);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(A_CTRL, v); chk("R1 ctrl", v, 32'h80);
    rd(A_SECS, v); chk("R1 secs", v, 0);
    rd(A_ALRM, v); chk("R1 alarm", v, 0);
    rd(A_SCR, v);  chk("R1 scratch", v, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 poff", {31'b0, poff}, 0);

    // R12 map
    wr(A_TRIM, 32'hA5A50F0F); rd(A_TRIM, v); chk("R12 trim", v, 32'hA5A50F0F);
    rd(A_NONE, v); chk("R12 unmapped", v, 0);
    wr(A_SCR, 32'h12345678); rd(A_SCR, v); chk("R9 scratch rw", v, 32'h12345678);

    // R2 hold length
    wr(A_SCR, 32'h1);
    begin
      int n = 0;
      forever begin
        rd(A_CTRL, v);
        if (v[7]) break;
        n++;
        @(negedge clk);
      end
      chk("R2 ready low cycles", n, HOLD);
    end
    // R2 sweep of write offsets
    for (int i = 1; i <= HOLD + 1; i++) begin
      wr(A_SCR, 32'h1000);
      repeat (i - 1) @(negedge clk);
      raw_wr(A_SCR, 32'h2000 + i);
      rd(A_SCR, v);
      chk("R2 busy write", v, (i > HOLD) ? 32'h2000 + i : 32'h1000);
    end

    // R3 / R4 counting
    wr(A_CTRL, 32'h01);
    repeat (DIV - 1) @(posedge clk); @(negedge clk);
    rd(A_SECS, v); chk("R3 before tick", v, 0);
    @(posedge clk); @(negedge clk);
    rd(A_SECS, v); chk("R3 first tick", v, 1);
    rd(A_CTRL, v); chk("R4 hz flag", {31'b0, v[6]}, 1);
    for (int k = 2; k <= 4; k++) begin
      repeat (DIV) @(posedge clk); @(negedge clk);
      rd(A_SECS, v); chk("R3 count", v, k);
    end
    wr(A_CTRL, 32'h00);
    rd(A_CTRL, v); chk("R6 clear hz", {31'b0, v[6]}, 0);
    repeat (3 * DIV) @(posedge clk); @(negedge clk);
    rd(A_SECS, v); chk("R3 hold disabled", v, 4);
    rd(A_CTRL, v); chk("R4 no flag disabled", {31'b0, v[6]}, 0);

    // R6 keep, then clear colliding with tick
    wr(A_CTRL, 32'h01);
    repeat (DIV) @(posedge clk); @(negedge clk);
    wr(A_CTRL, 32'h61);
    rd(A_CTRL, v); chk("R6 keep hz", {31'b0, v[6]}, 1);
    chk("R7 irq hz", {31'b0, irq}, 1);
    repeat (DIV - 2) @(posedge clk); @(negedge clk);
    raw_wr(A_CTRL, 32'h21);
    rd(A_CTRL, v); chk("R6 event wins", {31'b0, v[6]}, 1);
    wr(A_CTRL, 32'h21);
    rd(A_CTRL, v); chk("R6 clear later", {31'b0, v[6]}, 0);
    chk("R7 irq off", {31'b0, irq}, 0);

    // R11 seconds write on tick edge (write accepted at E_2DIV+5)
    repeat (DIV + 2) @(posedge clk); @(negedge clk);
    raw_wr(A_SECS, 32'd100);
    rd(A_SECS, v); chk("R11 write wins", v, 100);
    repeat (DIV) @(posedge clk); @(negedge clk);
    rd(A_SECS, v); chk("R11 count on", v, 101);

    // R5 alarm
    wr(A_CTRL, 32'h00);
    wr(A_SECS, 32'd0);
    wr(A_ALRM, 32'd3);
    wr(A_CTRL, 32'h0D);
    repeat (2 * DIV) @(posedge clk); @(negedge clk);
    rd(A_CTRL, v); chk("R5 not yet", {31'b0, v[4]}, 0);
    chk("R7 irq quiet", {31'b0, irq}, 0);
    repeat (DIV) @(posedge clk); @(negedge clk);
    rd(A_SECS, v); chk("R5 secs at match", v, 3);
    rd(A_CTRL, v); chk("R5 alarm set", {31'b0, v[4]}, 1);
    chk("R7 irq alarm", {31'b0, irq}, 1);
    wr(A_CTRL, 32'h09);
    wr(A_ALRM, 32'd5);
    repeat (3 * DIV) @(posedge clk); @(negedge clk);
    rd(A_CTRL, v); chk("R5 disabled no flag", {31'b0, v[4]}, 0);

    // R7 enable sweep with both flags set
    wr(A_CTRL, 32'h00);
    wr(A_SECS, 32'd0);
    wr(A_ALRM, 32'd1);
    wr(A_CTRL, 32'h05);
    repeat (DIV) @(posedge clk); @(negedge clk);
    for (int e = 0; e < 4; e++) begin
      wr(A_CTRL, 32'h50 | (e[0] ? 32'h20 : 32'h0) | (e[1] ? 32'h08 : 32'h0));
      chk("R7 enable sweep", {31'b0, irq}, {31'b0, e[0] | e[1]});
      rd(A_CTRL, v); chk("R6 flags kept", {30'b0, v[6], v[4]}, 32'h3);
    end
    wr(A_CTRL, 32'h48);
    chk("R7 hz only no ie", {31'b0, irq}, 0);

    // R8 hibernate
    wr(A_HIB, 32'h1);
    chk("R8 poff on", {31'b0, poff}, 1);
    rd(A_HIB, v); chk("R8 readback", v, 1);
    wr(A_HIB, 32'h0);
    chk("R8 poff off", {31'b0, poff}, 0);

    // R10 / R9 soft reset
    wr(A_SCR, 32'hCAFEF00D);
    wr(A_ALRM, 32'd7);
    wr(A_TRIM, 32'd9);
    wr(A_HIB, 32'h1);
    wr(A_CTRL, 32'h2C);
    rd(A_SECS, s_keep);
    addr = A_SCR; wd = 32'hDEAD0000; we = 1'b1; soft_rst = 1'b1;
    @(posedge clk); @(negedge clk);
    we = 1'b0; soft_rst = 1'b0;
    rd(A_CTRL, v); chk("R10 ctrl cleared", v, 32'h80);
    rd(A_ALRM, v); chk("R10 alarm cleared", v, 0);
    rd(A_TRIM, v); chk("R10 trim cleared", v, 0);
    rd(A_SECS, v); chk("R10 secs kept", v, s_keep);
    rd(A_SCR, v);  chk("R9 scratch kept", v, 32'hCAFEF00D);
    chk("R10 poff cleared", {31'b0, poff}, 0);

    // R1 / R9 power-on reset clears scratchpad
    por_n = 1'b0;
    @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    rd(A_SCR, v);  chk("R9 por clears scratch", v, 0);
    rd(A_SECS, v); chk("R1 por clears secs", v, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule